// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block fronts a small one-time-programmable fuse store of 256 bytes. The store is modelled as flops inside the block. Software reaches it through a plain register bus: a write strobe, a word address, write data, and read data that follows the address combinationally. Before any fuse access, a 16-bit arming word is written to a mode register. One value opens the store for reading and another opens it for programming. Any other value closes it.

The store is seen through a window of 128 bus words. Each word carries two fuse bytes. The even-addressed byte sits in the low lane and the odd-addressed byte sits in the next lane. Programming needs both the program arming and a set program-voltage enable bit. A program write can only turn bits on: the written lanes are ORed into the stored bytes.

Each accepted program write starts a busy period whose length comes from a clock-period register. No further program write is accepted until that period ends. A read-only status word reports the busy flag together with a manufacturing state and three boot-stage flags that arrive on input pins.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the block is disarmed, the clock-period register reads 0, the voltage-enable register reads 0, busy (status bit 8) is 0, and every fuse byte is 0.
- R2: Writing to offset 0x30 sets the arming from write-data bits [15:0], and bits [31:16] are ignored. 0x5A5A arms read and 0xA5A5 arms program. Any other value disarms. A read of 0x30 returns 0x00005A5A, 0x0000A5A5 or 0 for read-armed, program-armed and disarmed.
- R3: When read is armed, a read of window word w returns the fuse byte 2w in bits [7:0] and byte 2w+1 in bits [15:8], in the same cycle. Window word w is at offset 0x800 + 4·w, for w from 0 to 127. Bits [31:16] of the result are always 0.
- R4: A window read returns 0 whenever read is not armed.
- R5: With program armed, the voltage enable at 1 and busy at 0, a write to window word w ORs write-data [7:0] into byte 2w and [15:8] into byte 2w+1. Write-data [31:16] is ignored.
- R6: No fuse bit that is 1 ever returns to 0.
- R7: A window write leaves every fuse byte unchanged in any of three cases: program is not armed, voltage-enable bit 0 is 0, or busy is 1.
- R8: An accepted program write sets busy from the next cycle for exactly P+1 cycles, where P is the clock-period register at the time of the write.
- R9: The clock-period register at 0x34 holds write-data [7:0] and reads it back. The voltage-enable register at 0x3C holds write-data bit 0 and reads it back as bit 0.
- R10: The status register at 0x2C reads mfg_state in bits [1:0], boot_stage_done in bits [4:2] and busy in bit 8, with all other bits 0. Writes to it and to unused offsets have no effect. Unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address of the register or window word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mfg_state | input | 2 | Manufacturing state shown in status |
| boot_stage_done | input | 3 | Boot-stage completion flags shown in status |

## Verification
Program writes use lane patterns that differ between the even and odd byte, so that swapped lanes or a wrong word index give a visibly wrong word. The tests also cover the last window word and write data with the upper half set, which exposes an upper-lane leak.

A second program write to an already-programmed word adds bits that overlap and bits that are new. This separates OR behaviour from overwrite behaviour. Window writes are also tried under each missing interlock condition and during busy, to show that each one gates the write on its own.

The arming register is driven with both magics, an unrelated value, and a magic that carries junk in its upper half. The busy length is measured for two period values.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

   typedef enum logic [1:0] {
      ARM_NONE = 2'd0,
      ARM_READ = 2'd1,
      ARM_PROG = 2'd2
   } arm_e;

   localparam logic [15:0] MAGIC_READ = 16'h5A5A;
   localparam logic [15:0] MAGIC_PROG = 16'hA5A5;

   localparam int unsigned OFF_STATUS = 32'h02C;
   localparam int unsigned OFF_MODE   = 32'h030;
   localparam int unsigned OFF_PERIOD = 32'h034;
   localparam int unsigned OFF_VPP    = 32'h03C;

   localparam int LANE_W     = 8;
   localparam int WORD_LANES = 2;
   localparam int STORE_W    = LANE_W * WORD_LANES;

endpackage

// File: rtl/otp_arm_regs.sv
module otp_arm_regs
   import otp_fuse_pkg::*;
#(
   parameter int PER_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_mode,
   input  logic             wr_period,
   input  logic             wr_vpp,
   input  logic [31:0]      wdata,
   input  logic             prog_fire,
   output arm_e             arm_mode,
   output logic [PER_W-1:0] period_q,
   output logic             vpp_en,
   output logic             busy
);

   logic [PER_W-1:0] cnt_q;

   generate
      if (PER_W < 1 || PER_W > 16) begin : g_bad_per
         $error("otp_arm_regs: PER_W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_mode <= ARM_NONE;
      end else if (wr_mode) begin
         case (wdata[15:0])
            MAGIC_READ: arm_mode <= ARM_READ;
            MAGIC_PROG: arm_mode <= ARM_PROG;
            default:    arm_mode <= ARM_NONE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         vpp_en   <= 1'b0;
      end else begin
         if (wr_period) period_q <= wdata[PER_W-1:0];
         if (wr_vpp)    vpp_en   <= wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (prog_fire) begin
         busy  <= 1'b1;
         cnt_q <= period_q;
      end else if (busy) begin
         if (cnt_q == '0) busy  <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
   import otp_fuse_pkg::*;
#(
   parameter int WORDS = 128,
   parameter int IDX_W = $clog2(WORDS),
   parameter int IMG_W = WORDS * STORE_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_en,
   input  logic [IDX_W-1:0]   prog_idx,
   input  logic [STORE_W-1:0] prog_bits,
   output logic [IMG_W-1:0]   image
);

   generate
      if (IMG_W != WORDS * STORE_W) begin : g_bad_img
         $error("otp_fuse_array: IMG_W mismatch");
      end
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         logic [STORE_W-1:0] cell_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cell_q <= '0;
            end else if (prog_en && (prog_idx == IDX_W'(w))) begin
               cell_q <= cell_q | prog_bits;
            end
         end
         assign image[w*STORE_W +: STORE_W] = cell_q;
      end
   endgenerate

endmodule

// File: rtl/otp_lane_pack.sv
module otp_lane_pack
   import otp_fuse_pkg::*;
#(
   parameter int WORDS = 128,
   parameter int IDX_W = $clog2(WORDS),
   parameter int BUS_W = 32
)(
   input  logic [WORDS*STORE_W-1:0] image,
   input  logic [IDX_W-1:0]         idx,
   input  logic                     en,
   output logic [BUS_W-1:0]         word
);

   logic [STORE_W-1:0] lanes;

   always_comb begin
      lanes = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (idx == IDX_W'(w)) lanes = image[w*STORE_W +: STORE_W];
      end
   end

   generate
      if (BUS_W < STORE_W) begin : g_bad_bus
         $error("otp_lane_pack: bus narrower than a fuse word pair");
      end else if (BUS_W == STORE_W) begin : g_exact
         assign word = en ? lanes : '0;
      end else begin : g_pad
         assign word = en ? {{(BUS_W-STORE_W){1'b0}}, lanes} : '0;
      end
   endgenerate

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
   import otp_fuse_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int FUSE_BYTES = 256,
   parameter int BUS_W      = 32,
   parameter int PER_W      = 8,
   parameter int WIN_BASE   = 32'h800
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [1:0]        mfg_state,
   input  logic [2:0]        boot_stage_done
);

   localparam int WORDS   = FUSE_BYTES / WORD_LANES;
   localparam int IDX_W   = $clog2(WORDS);
   localparam int IMG_W   = FUSE_BYTES * LANE_W;
   localparam int WIN_END = WIN_BASE + WORDS * 4;
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFF_MODE);
   localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFF_PERIOD);
   localparam logic [ADDR_W-1:0] A_VPP    = ADDR_W'(OFF_VPP);

   generate
      if (FUSE_BYTES % WORD_LANES != 0) begin : g_bad_bytes
         $error("otp_fuse_ctrl: FUSE_BYTES must be even");
      end
      if (WIN_END > (1 << ADDR_W)) begin : g_bad_win
         $error("otp_fuse_ctrl: window exceeds address space");
      end
      if (BUS_W < 32) begin : g_bad_bus
         $error("otp_fuse_ctrl: BUS_W must be at least 32");
      end
      if (WIN_BASE <= int'(OFF_VPP)) begin : g_bad_base
         $error("otp_fuse_ctrl: window overlaps registers");
      end
   endgenerate

   arm_e               arm_mode;
   logic [PER_W-1:0]   period_q;
   logic               vpp_en;
   logic               busy;
   logic [IMG_W-1:0]   fuse_image;
   logic               win_hit;
   logic [ADDR_W-1:0]  win_off;
   logic [IDX_W-1:0]   win_idx;
   logic [BUS_W-1:0]   win_word;
   logic               sel_status, sel_mode, sel_period, sel_vpp;
   logic               prog_fire;

   assign win_hit = ({1'b0, bus_addr} >= (ADDR_W+1)'(WIN_BASE)) &&
                    ({1'b0, bus_addr} <  (ADDR_W+1)'(WIN_END));
   assign win_off = bus_addr - ADDR_W'(WIN_BASE);
   assign win_idx = win_off[IDX_W+1:2];

   assign sel_status = bus_addr[ADDR_W-1:2] == A_STATUS[ADDR_W-1:2];
   assign sel_mode   = bus_addr[ADDR_W-1:2] == A_MODE[ADDR_W-1:2];
   assign sel_period = bus_addr[ADDR_W-1:2] == A_PERIOD[ADDR_W-1:2];
   assign sel_vpp    = bus_addr[ADDR_W-1:2] == A_VPP[ADDR_W-1:2];

   assign prog_fire = bus_we && win_hit && (arm_mode == ARM_PROG) && vpp_en && !busy;

   otp_arm_regs #(.PER_W(PER_W)) u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (bus_we && sel_mode),
      .wr_period (bus_we && sel_period),
      .wr_vpp    (bus_we && sel_vpp),
      .wdata     (bus_wdata[31:0]),
      .prog_fire (prog_fire),
      .arm_mode  (arm_mode),
      .period_q  (period_q),
      .vpp_en    (vpp_en),
      .busy      (busy)
   );

   otp_fuse_array #(.WORDS(WORDS), .IDX_W(IDX_W), .IMG_W(IMG_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_en   (prog_fire),
      .prog_idx  (win_idx),
      .prog_bits (bus_wdata[STORE_W-1:0]),
      .image     (fuse_image)
   );

   otp_lane_pack #(.WORDS(WORDS), .IDX_W(IDX_W), .BUS_W(BUS_W)) u_pack (
      .image (fuse_image),
      .idx   (win_idx),
      .en    (arm_mode == ARM_READ),
      .word  (win_word)
   );

   always_comb begin
      bus_rdata = '0;
      if (win_hit) begin
         bus_rdata = win_word;
      end else if (sel_status) begin
         bus_rdata = BUS_W'({busy, 3'b000, boot_stage_done, mfg_state});
      end else if (sel_mode) begin
         case (arm_mode)
            ARM_READ: bus_rdata = BUS_W'(MAGIC_READ);
            ARM_PROG: bus_rdata = BUS_W'(MAGIC_PROG);
            default:  bus_rdata = '0;
         endcase
      end else if (sel_period) begin
         bus_rdata = BUS_W'(period_q);
      end else if (sel_vpp) begin
         bus_rdata = BUS_W'(vpp_en);
      end
   end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
   import otp_fuse_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int FUSE_BYTES = 256,
   parameter int BUS_W      = 32,
   parameter int WIN_BASE   = 32'h800
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_we,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [BUS_W-1:0]        bus_rdata,
   input arm_e                    arm_mode,
   input logic                    vpp_en,
   input logic                    busy,
   input logic [FUSE_BYTES*8-1:0] fuse_image
);

   localparam int WIN_END = WIN_BASE + (FUSE_BYTES / 2) * 4;

   logic in_win;
   assign in_win = ({1'b0, bus_addr} >= (ADDR_W+1)'(WIN_BASE)) &&
                   ({1'b0, bus_addr} <  (ADDR_W+1)'(WIN_END));

   p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> (bus_rdata[BUS_W-1:16] == '0));

   p_unarmed_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && arm_mode != ARM_READ) |-> (bus_rdata == '0));

   p_or_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(fuse_image) & ~fuse_image) == '0));

   p_interlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(arm_mode == ARM_PROG && vpp_en) || busy) |=> $stable(fuse_image));

   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && in_win && arm_mode == ARM_PROG && vpp_en && !busy) |=> busy);

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
   .ADDR_W(ADDR_W), .FUSE_BYTES(FUSE_BYTES), .BUS_W(BUS_W), .WIN_BASE(WIN_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .arm_mode   (arm_mode),
   .vpp_en     (vpp_en),
   .busy       (busy),
   .fuse_image (fuse_image)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] A_STS = 12'h02C;
   localparam logic [11:0] A_MOD = 12'h030;
   localparam logic [11:0] A_PER = 12'h034;
   localparam logic [11:0] A_VPP = 12'h03C;
   localparam logic [11:0] A_WIN = 12'h800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  mfg_state = 2'b10;
   logic [2:0]  boot_stage_done = 3'b101;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_fuse_ctrl u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .bus_we          (bus_we),
      .bus_addr        (bus_addr),
      .bus_wdata       (bus_wdata),
      .bus_rdata       (bus_rdata),
      .mfg_state       (mfg_state),
      .boot_stage_done (boot_stage_done)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 600; i++) begin
         rd(A_STS, s);
         if (!s[8]) break;
         @(negedge clk);
      end
   endtask

   task automatic read_word(input int w, output logic [31:0] d);
      wr(A_MOD, 32'h5A5A);
      rd(A_WIN + 12'(w*4), d);
   endtask

   task automatic prog_word(input int w, input logic [31:0] d);
      wr(A_MOD, 32'hA5A5);
      wr(A_VPP, 32'h1);
      wr(A_WIN + 12'(w*4), d);
      wr(A_VPP, 32'h0);
      wait_idle();
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_STS, v); chk("R1 status busy clear", v, 32'h16);
      rd(A_PER, v); chk("R1 period reset", v, 32'h0);
      rd(A_VPP, v); chk("R1 vpp reset", v, 32'h0);
      rd(A_MOD, v); chk("R1 disarmed", v, 32'h0);
      rd(A_WIN, v); chk("R4 unarmed window read", v, 32'h0);
      read_word(0, v);   chk("R1 fuse word 0 blank", v, 32'h0);
      read_word(127, v); chk("R1 fuse word 127 blank", v, 32'h0);
      wr(A_MOD, 32'h0);
   endtask

   task automatic t_arm();
      logic [31:0] v;
      wr(A_MOD, 32'h5A5A);     rd(A_MOD, v); chk("R2 read arm", v, 32'h5A5A);
      wr(A_MOD, 32'hA5A5);     rd(A_MOD, v); chk("R2 program arm", v, 32'hA5A5);
      wr(A_MOD, 32'h1234);     rd(A_MOD, v); chk("R2 other disarms", v, 32'h0);
      wr(A_MOD, 32'hFFFF5A5A); rd(A_MOD, v); chk("R2 upper bits ignored", v, 32'h5A5A);
      wr(A_MOD, 32'h5A5B);     rd(A_MOD, v); chk("R2 near-magic disarms", v, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(A_PER, 32'h1FF); rd(A_PER, v); chk("R9 period 8 bits", v, 32'hFF);
      wr(A_VPP, 32'h3);   rd(A_VPP, v); chk("R9 vpp bit0", v, 32'h1);
      wr(A_VPP, 32'h2);   rd(A_VPP, v); chk("R9 vpp cleared", v, 32'h0);
      wr(A_PER, 32'h2);
   endtask

   task automatic t_program();
      logic [31:0] v;
      prog_word(5, 32'hFFFF_3C81);
      read_word(5, v); chk("R5 lanes even/odd, upper ignored", v, 32'h0000_3C81);
      read_word(4, v); chk("R5 neighbour untouched", v, 32'h0);
      read_word(6, v); chk("R5 neighbour untouched", v, 32'h0);
      prog_word(127, 32'h0000_A500);
      read_word(127, v); chk("R3 last word odd byte 255", v, 32'h0000_A500);
   endtask

   task automatic t_or_only();
      logic [31:0] v;
      prog_word(5, 32'h0000_4201);
      read_word(5, v); chk("R6 OR merge", v, 32'h0000_7E81);
      prog_word(5, 32'h0000_0000);
      read_word(5, v); chk("R6 zero write keeps bits", v, 32'h0000_7E81);
   endtask

   task automatic t_interlock();
      logic [31:0] v;
      wr(A_MOD, 32'hA5A5); wr(A_VPP, 32'h0);
      wr(A_WIN + 12'd28, 32'hFFFF);
      read_word(7, v); chk("R7 vpp off ignored", v, 32'h0);
      wr(A_VPP, 32'h1);
      wr(A_WIN + 12'd28, 32'hFFFF);
      read_word(7, v); chk("R7 read mode ignored", v, 32'h0);
      wr(A_MOD, 32'h0);
      wr(A_WIN + 12'd28, 32'hFFFF);
      read_word(7, v); chk("R7 disarmed ignored", v, 32'h0);
      wr(A_VPP, 32'h0);
   endtask

   task automatic t_busy(input logic [7:0] per);
      logic [31:0] s;
      int cnt;
      wr(A_PER, {24'h0, per});
      wr(A_MOD, 32'hA5A5); wr(A_VPP, 32'h1);
      wr(A_WIN + 12'd36, 32'h0001);
      cnt = 0;
      for (int i = 0; i < 600; i++) begin
         rd(A_STS, s);
         if (!s[8]) break;
         cnt++;
         @(negedge clk);
      end
      chk("R8 busy length", cnt, 32'(per) + 1);
      wr(A_VPP, 32'h0);
   endtask

   task automatic t_busy_block();
      logic [31:0] v;
      wr(A_PER, 32'h5);
      wr(A_MOD, 32'hA5A5); wr(A_VPP, 32'h1);
      wr(A_WIN + 12'd40, 32'h0011);
      wr(A_WIN + 12'd44, 32'h00FF);
      wait_idle();
      wr(A_VPP, 32'h0);
      read_word(11, v); chk("R7 write while busy ignored", v, 32'h0);
      read_word(10, v); chk("R8 first write landed", v, 32'h0011);
   endtask

   task automatic t_status();
      logic [31:0] v;
      wr(A_STS, 32'hFFFF_FFFF);
      rd(A_STS, v); chk("R10 status read-only", v, 32'h16);
      mfg_state = 2'b01; boot_stage_done = 3'b010;
      rd(A_STS, v); chk("R10 status fields", v, 32'h09);
      wr(A_PER, 32'h7);
      wr(12'h038, 32'hFFFF_FFFF);
      rd(12'h038, v); chk("R10 unused reads zero", v, 32'h0);
      rd(A_PER, v);   chk("R10 unused write no effect", v, 32'h7);
      wr(A_MOD, 32'h5A5A);
      rd(12'hA00, v); chk("R10 past window reads zero", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_arm();
      t_regs();
      t_program();
      t_or_only();
      t_interlock();
      t_busy(8'd0);
      t_busy(8'd3);
      t_busy_block();
      t_status();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule